// File: doc/BRIEF.md
# DAC Sample Formatter with Cyclic Prefix

This block sits between an inverse FFT and a high-speed digital-to-analog converter in an OFDM transmitter. It accepts the time-domain symbols as wide beats of P samples per clock. For each frame it plays out a preamble held in local storage. Ahead of every symbol it inserts a cyclic prefix, which is a copy of the symbol's own tail. It then turns every sample into a DAC code: it rounds to the DAC width, saturates, and emits the result in two's complement or offset binary.

Each incoming symbol is captured whole in one of two ping-pong banks, so that its tail can be read out before its head. A sequencer walks the preamble, the prefix and the body in order and hands up to P quantized samples per cycle to a repacking stage. The repacking stage closes every gap, so the output carries exactly P samples per beat even when the preamble or prefix length is not a multiple of P. A frame ends on the symbol marked last. Its final output beat is flagged, and any unused lanes in that beat are padded with the code for zero.

The prefix length, the preamble length and the output format are static inputs that may only change between frames. The preamble storage is filled one sample per cycle through a plain write port.

Top module: `dacfmt_top`

## Requirements
- R1: After reset, `m_valid` and `m_last` are low and `s_ready` is high.
- R2: A symbol is SYM_N samples delivered as SYM_N/P beats, with sample beat*P+j on input lane j (bits j*IN_W up). Two whole symbols can be held. While both are held, `s_ready` is low. `s_last` on a symbol's final beat marks the last symbol of the frame.
- R3: A frame starts with samples 0 to `cfg_pre_len`-1 of the preamble storage, in address order. A length of zero sends no preamble. Storage address `pre_addr` takes `pre_wdata` on a cycle with `pre_we` high.
- R4: Every symbol is sent as its last `cfg_cp_len` samples (0 to 16, in their original order), followed by all SYM_N samples in order. A length of zero sends no prefix.
- R5: The output sample stream is packed P per beat with no holes. The earliest sample is on lane 0, and lane j occupies bits j*DAC_W up. This holds for every preamble and prefix length.
- R6: The beat that holds the last sample of a frame has `m_last` high. Its lanes past that sample carry the converted value of zero. No beat follows until the next frame's data arrives.
- R7: Rounding adds 2^(IN_W-DAC_W-1) to the sample and takes the floor after dropping IN_W-DAC_W bits (round half up).
- R8: A rounded value above 2^(DAC_W-1)-1 becomes that value. One below -2^(DAC_W-1) becomes that value. Values never wrap.
- R9: With `cfg_offset_bin` high, the most significant bit of each saturated code is inverted (offset binary). With it low, the code is two's complement.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cp_len | input | 5 | Cyclic prefix length in samples (0 to 16) |
| cfg_pre_len | input | 7 | Preamble length in samples (0 to 64) |
| cfg_offset_bin | input | 1 | 1 selects offset binary output, 0 two's complement |
| pre_we | input | 1 | Preamble storage write enable |
| pre_addr | input | 6 | Preamble storage write address |
| pre_wdata | input | 16 | Preamble sample to write |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_data | input | 128 | P input samples, two's complement |
| s_last | input | 1 | Beat belongs to the last symbol of the frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 96 | P DAC codes |
| m_last | output | 1 | Final beat of the frame |

## Verification
The edge that accepts a symbol's final input beat marks it stored. The sequencer leaves idle on the following edge. Its first push is registered in the repacking stage one edge later, so the earliest output beat of a symbol is visible two edges after its last input beat. Quantization is combinational inside the push cycle, so a sample's code appears in the beat registered on its push edge. Because back-pressure and the ping-pong banks stretch these delays, the checks count no cycles. A scoreboard holds the expected beats in order, and every beat accepted at the output is compared against the next one. The only timed check is the hold rule: a beat that stalls on one edge is compared on the very next sampling point.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CP,
    SQ_SYM
  } seq_state_e;

endpackage

// File: rtl/dacfmt_quant.sv
module dacfmt_quant #(
  parameter int IN_W  = 16,
  parameter int DAC_W = 12
) (
  input  logic [IN_W-1:0]  smp_i,
  input  logic             offset_bin_i,
  output logic [DAC_W-1:0] code_o
);

  localparam int DROP = IN_W - DAC_W;

  logic [IN_W:0]      ext;
  logic [IN_W:0]      sum;
  logic [IN_W:0]      shr;
  logic [IN_W-DAC_W+1:0] upper;
  logic               ovf;
  logic [DAC_W-1:0]   sat;

  always_comb begin
    ext   = {smp_i[IN_W-1], smp_i};
    sum   = ext + ((IN_W+1)'(1) << (DROP-1));
    shr   = {{DROP{sum[IN_W]}}, sum[IN_W:DROP]};
    upper = shr[IN_W:DAC_W-1];
    ovf   = !((&upper) || !(|upper));
    if (ovf) begin
      sat = shr[IN_W] ? {1'b1, {(DAC_W-1){1'b0}}} : {1'b0, {(DAC_W-1){1'b1}}};
    end else begin
      sat = shr[DAC_W-1:0];
    end
    code_o = offset_bin_i ? {~sat[DAC_W-1], sat[DAC_W-2:0]} : sat;
  end

endmodule

// File: rtl/dacfmt_symbuf.sv
module dacfmt_symbuf #(
  parameter int P     = 8,
  parameter int IN_W  = 16,
  parameter int SYM_N = 64,
  localparam int IW    = $clog2(SYM_N),
  localparam int BEATS = SYM_N / P,
  localparam int BW    = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [P*IN_W-1:0] s_data,
  input  logic              s_last,
  input  logic [P*IW-1:0]   rd_idx_i,
  output logic [P*IN_W-1:0] rd_smp_o,
  output logic              rd_full_o,
  output logic              rd_eof_o,
  input  logic              rd_release_i
);

  logic [IN_W-1:0] mem [2][SYM_N];

  logic          wr_bank, wr_bank_n;
  logic          rd_bank, rd_bank_n;
  logic [BW-1:0] wr_beat, wr_beat_n;
  logic [1:0]    full, full_n;
  logic [1:0]    eof, eof_n;
  logic          wr_fire, wr_end;

  assign s_ready   = !full[wr_bank];
  assign wr_fire   = s_valid && s_ready;
  assign wr_end    = wr_fire && (wr_beat == BW'(BEATS-1));
  assign rd_full_o = full[rd_bank];
  assign rd_eof_o  = eof[rd_bank];

  always_comb begin
    full_n    = full;
    eof_n     = eof;
    wr_beat_n = wr_beat;
    if (wr_fire) begin
      wr_beat_n = wr_end ? '0 : wr_beat + BW'(1);
    end
    if (wr_end) begin
      full_n[wr_bank] = 1'b1;
      eof_n[wr_bank]  = s_last;
    end
    if (rd_release_i) begin
      full_n[rd_bank] = 1'b0;
    end
    wr_bank_n = wr_bank ^ wr_end;
    rd_bank_n = rd_bank ^ rd_release_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_beat <= '0;
      full    <= '0;
      eof     <= '0;
    end else begin
      wr_bank <= wr_bank_n;
      rd_bank <= rd_bank_n;
      wr_beat <= wr_beat_n;
      full    <= full_n;
      eof     <= eof_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int j = 0; j < P; j++) begin
        mem[wr_bank][IW'(wr_beat) * IW'(P) + IW'(j)] <= s_data[j*IN_W +: IN_W];
      end
    end
  end

  for (genvar j = 0; j < P; j++) begin : g_rd
    assign rd_smp_o[j*IN_W +: IN_W] = mem[rd_bank][rd_idx_i[j*IW +: IW]];
  end

  AST_RELEASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release_i |-> full[rd_bank]); // R2

  AST_BLOCK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (&full) |-> !s_ready); // R2

endmodule

// File: rtl/dacfmt_seq.sv
module dacfmt_seq
  import dacfmt_pkg::*;
#(
  parameter int P       = 8,
  parameter int IN_W    = 16,
  parameter int DAC_W   = 12,
  parameter int SYM_N   = 64,
  parameter int CP_MAX  = 16,
  parameter int PRE_MAX = 64,
  localparam int IW   = $clog2(SYM_N),
  localparam int CPW  = $clog2(CP_MAX+1),
  localparam int PLW  = $clog2(PRE_MAX+1),
  localparam int PAW  = $clog2(PRE_MAX),
  localparam int KW   = $clog2(P+1),
  localparam int LMAX = (SYM_N > PRE_MAX) ? SYM_N : PRE_MAX,
  localparam int PW   = $clog2(LMAX+CP_MAX+P+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPW-1:0]     cfg_cp_len,
  input  logic [PLW-1:0]     cfg_pre_len,
  input  logic               cfg_offset_bin,
  input  logic               pre_we,
  input  logic [PAW-1:0]     pre_addr,
  input  logic [IN_W-1:0]    pre_wdata,
  input  logic               rd_full_i,
  input  logic               rd_eof_i,
  output logic [P*IW-1:0]    rd_idx_o,
  input  logic [P*IN_W-1:0]  rd_smp_i,
  output logic               rd_release_o,
  input  logic               room_i,
  input  logic               fin_i,
  output logic [KW-1:0]      push_k_o,
  output logic [P*DAC_W-1:0] push_data_o,
  output logic               push_eof_o
);

  logic [IN_W-1:0] pre_mem [PRE_MAX];

  seq_state_e    st, st_n;
  logic [PW-1:0] pos, pos_n;
  logic          in_frame, frame_n;
  logic          st_en;
  logic [PW-1:0] cp_eff, pre_eff, seg_len, remain;
  logic [KW-1:0] take;
  logic          seg_end, active;

  always_comb begin
    cp_eff  = (cfg_cp_len  > CPW'(CP_MAX))  ? PW'(CP_MAX)  : PW'(cfg_cp_len);
    pre_eff = (cfg_pre_len > PLW'(PRE_MAX)) ? PW'(PRE_MAX) : PW'(cfg_pre_len);
    unique case (st)
      SQ_PRE:  seg_len = pre_eff;
      SQ_CP:   seg_len = cp_eff;
      SQ_SYM:  seg_len = PW'(SYM_N);
      default: seg_len = '0;
    endcase
    remain  = seg_len - pos;
    seg_end = (remain <= PW'(P));
    take    = seg_end ? KW'(remain) : KW'(P);
    active  = (st != SQ_IDLE) && room_i;
  end

  assign push_k_o = active ? take : '0;

  // per-lane source selection and quantization
  for (genvar j = 0; j < P; j++) begin : g_lane
    logic [PW-1:0]   lidx;
    logic [PW-1:0]   sidx;
    logic [IN_W-1:0] pre_smp;
    logic [IN_W-1:0] raw;

    always_comb begin
      lidx = pos + PW'(j);
      sidx = (st == SQ_CP) ? lidx + PW'(SYM_N) - cp_eff : lidx;
      pre_smp = (lidx < PW'(PRE_MAX)) ? pre_mem[PAW'(lidx)] : '0;
      raw = (st == SQ_PRE) ? pre_smp : rd_smp_i[j*IN_W +: IN_W];
    end

    assign rd_idx_o[j*IW +: IW] = IW'(sidx);

    dacfmt_quant #(
      .IN_W  (IN_W),
      .DAC_W (DAC_W)
    ) i_quant (
      .smp_i        (raw),
      .offset_bin_i (cfg_offset_bin),
      .code_o       (push_data_o[j*DAC_W +: DAC_W])
    );
  end

  always_comb begin
    st_n         = st;
    pos_n        = pos;
    frame_n      = in_frame;
    rd_release_o = 1'b0;
    push_eof_o   = 1'b0;
    st_en        = 1'b0;
    if (st == SQ_IDLE) begin
      if (rd_full_i && !fin_i) begin
        st_en   = 1'b1;
        pos_n   = '0;
        frame_n = 1'b1;
        if (!in_frame && (pre_eff != '0)) begin
          st_n = SQ_PRE;
        end else if (cp_eff != '0) begin
          st_n = SQ_CP;
        end else begin
          st_n = SQ_SYM;
        end
      end
    end else if (room_i) begin
      st_en = 1'b1;
      if (seg_end) begin
        pos_n = '0;
        unique case (st)
          SQ_PRE:  st_n = (cp_eff != '0) ? SQ_CP : SQ_SYM;
          SQ_CP:   st_n = SQ_SYM;
          default: begin
            st_n         = SQ_IDLE;
            rd_release_o = 1'b1;
            if (rd_eof_i) begin
              push_eof_o = 1'b1;
              frame_n    = 1'b0;
            end
          end
        endcase
      end else begin
        pos_n = pos + PW'(take);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      pos      <= '0;
      in_frame <= 1'b0;
    end else if (st_en) begin
      st       <= st_n;
      pos      <= pos_n;
      in_frame <= frame_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pre_we) begin
      pre_mem[pre_addr] <= pre_wdata;
    end
  end

  AST_POS_IN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_IDLE) |-> (pos < seg_len)); // R4

  AST_RELEASE_AFTER_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release_o |-> rd_full_i); // R2

endmodule

// File: rtl/dacfmt_pack.sv
module dacfmt_pack #(
  parameter int P     = 8,
  parameter int DAC_W = 12,
  localparam int KW   = $clog2(P+1),
  localparam int CW   = $clog2(2*P+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               offset_bin_i,
  input  logic [KW-1:0]      push_k_i,
  input  logic [P*DAC_W-1:0] push_data_i,
  input  logic               push_eof_i,
  output logic               room_o,
  output logic               fin_o,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [P*DAC_W-1:0] m_data,
  output logic               m_last
);

  logic [DAC_W-1:0] slot   [2*P];
  logic [DAC_W-1:0] slot_n [2*P];
  logic [DAC_W-1:0] lane_in [P];
  logic [CW-1:0]    cnt, cnt_n, cnt_ap;
  logic             fin, fin_n;
  logic             pop;
  logic [DAC_W-1:0] pad;

  assign pad     = {offset_bin_i, {(DAC_W-1){1'b0}}};
  assign m_valid = (cnt >= CW'(P)) || (fin && (cnt != '0));
  assign m_last  = fin && (cnt <= CW'(P));
  assign pop     = m_valid && m_ready;
  assign fin_o   = fin;

  always_comb begin
    if (!pop) begin
      cnt_ap = cnt;
    end else if (cnt >= CW'(P)) begin
      cnt_ap = cnt - CW'(P);
    end else begin
      cnt_ap = '0;
    end
  end

  assign room_o = (cnt_ap <= CW'(P));

  for (genvar j = 0; j < P; j++) begin : g_unpack
    assign lane_in[j] = push_data_i[j*DAC_W +: DAC_W];
    assign m_data[j*DAC_W +: DAC_W] = (CW'(j) < cnt) ? slot[j] : pad;
  end

  always_comb begin
    for (int i = 0; i < 2*P; i++) begin
      int off;
      if (pop) begin
        slot_n[i] = (i < P) ? slot[(i+P) % (2*P)] : slot[i];
      end else begin
        slot_n[i] = slot[i];
      end
      off = i - int'(cnt_ap);
      if ((off >= 0) && (off < int'(push_k_i))) begin
        slot_n[i] = lane_in[off % P];
      end
    end
    cnt_n = cnt_ap + CW'(push_k_i);
    fin_n = fin;
    if (pop && m_last) begin
      fin_n = 1'b0;
    end
    if (push_eof_i) begin
      fin_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      cnt <= cnt_n;
      fin <= fin_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2*P; i++) begin
      slot[i] <= slot_n[i];
    end
  end

  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_k_i != '0) |-> ((cnt_ap + CW'(push_k_i)) <= CW'(2*P))); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(2*P)); // R5

  AST_NO_PUSH_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (push_k_i == '0)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R10

endmodule

// File: rtl/dacfmt_top.sv
module dacfmt_top #(
  parameter int P       = 8,
  parameter int IN_W    = 16,
  parameter int DAC_W   = 12,
  parameter int SYM_N   = 64,
  parameter int CP_MAX  = 16,
  parameter int PRE_MAX = 64,
  localparam int IW  = $clog2(SYM_N),
  localparam int CPW = $clog2(CP_MAX+1),
  localparam int PLW = $clog2(PRE_MAX+1),
  localparam int PAW = $clog2(PRE_MAX),
  localparam int KW  = $clog2(P+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPW-1:0]     cfg_cp_len,
  input  logic [PLW-1:0]     cfg_pre_len,
  input  logic               cfg_offset_bin,
  input  logic               pre_we,
  input  logic [PAW-1:0]     pre_addr,
  input  logic [IN_W-1:0]    pre_wdata,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [P*IN_W-1:0]  s_data,
  input  logic               s_last,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [P*DAC_W-1:0] m_data,
  output logic               m_last
);

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [P*IW-1:0]    rd_idx;
  logic [P*IN_W-1:0]  rd_smp;
  logic               rd_full, rd_eof, rd_release;
  logic               room, fin;
  logic [KW-1:0]      push_k;
  logic [P*DAC_W-1:0] push_data;
  logic               push_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync[1];

  dacfmt_symbuf #(
    .P     (P),
    .IN_W  (IN_W),
    .SYM_N (SYM_N)
  ) i_symbuf (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_data       (s_data),
    .s_last       (s_last),
    .rd_idx_i     (rd_idx),
    .rd_smp_o     (rd_smp),
    .rd_full_o    (rd_full),
    .rd_eof_o     (rd_eof),
    .rd_release_i (rd_release)
  );

  dacfmt_seq #(
    .P       (P),
    .IN_W    (IN_W),
    .DAC_W   (DAC_W),
    .SYM_N   (SYM_N),
    .CP_MAX  (CP_MAX),
    .PRE_MAX (PRE_MAX)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .cfg_cp_len     (cfg_cp_len),
    .cfg_pre_len    (cfg_pre_len),
    .cfg_offset_bin (cfg_offset_bin),
    .pre_we         (pre_we),
    .pre_addr       (pre_addr),
    .pre_wdata      (pre_wdata),
    .rd_full_i      (rd_full),
    .rd_eof_i       (rd_eof),
    .rd_idx_o       (rd_idx),
    .rd_smp_i       (rd_smp),
    .rd_release_o   (rd_release),
    .room_i         (room),
    .fin_i          (fin),
    .push_k_o       (push_k),
    .push_data_o    (push_data),
    .push_eof_o     (push_eof)
  );

  dacfmt_pack #(
    .P     (P),
    .DAC_W (DAC_W)
  ) i_pack (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .offset_bin_i (cfg_offset_bin),
    .push_k_i     (push_k),
    .push_data_i  (push_data),
    .push_eof_i   (push_eof),
    .room_o       (room),
    .fin_o        (fin),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_data       (m_data),
    .m_last       (m_last)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!m_valid && !m_last)); // R1

endmodule

// File: tb/test_dacfmt_top.sv
module test_dacfmt_top;

  localparam int P     = 8;
  localparam int IN_W  = 16;
  localparam int DAC_W = 12;
  localparam int SYM_N = 64;
  localparam int BEATS = SYM_N / P;
  localparam int DROP  = IN_W - DAC_W;
  localparam int MAXC  = (1 << (DAC_W-1)) - 1;
  localparam int MINC  = -(1 << (DAC_W-1));
  localparam int VW    = P * DAC_W;

  typedef struct {
    logic [VW-1:0] d;
    logic          l;
    string         tag;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [4:0]       cfg_cp_len;
  logic [6:0]       cfg_pre_len;
  logic             cfg_offset_bin;
  logic             pre_we;
  logic [5:0]       pre_addr;
  logic [IN_W-1:0]  pre_wdata;
  logic             s_valid;
  logic             s_ready;
  logic [P*IN_W-1:0] s_data;
  logic             s_last;
  logic             m_valid;
  logic             m_ready;
  logic [VW-1:0]    m_data;
  logic             m_last;

  exp_t sb[$];
  int   n_chk;
  int   n_err;
  int   bp_mode;
  bit   mon_on;
  bit   done;

  dacfmt_top i_dacfmt_top (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_cp_len     (cfg_cp_len),
    .cfg_pre_len    (cfg_pre_len),
    .cfg_offset_bin (cfg_offset_bin),
    .pre_we         (pre_we),
    .pre_addr       (pre_addr),
    .pre_wdata      (pre_wdata),
    .s_valid        (s_valid),
    .s_ready        (s_ready),
    .s_data         (s_data),
    .s_last         (s_last),
    .m_valid        (m_valid),
    .m_ready        (m_ready),
    .m_data         (m_data),
    .m_last         (m_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // reference quantizer: round half up, saturate, optional MSB flip (R7 R8 R9)
  function automatic int qref(input int x, input bit ob);
    int r;
    r = (x + (1 << (DROP-1))) >>> DROP;
    if (r > MAXC) r = MAXC;
    if (r < MINC) r = MINC;
    r = r & ((1 << DAC_W) - 1);
    if (ob) r = r ^ (1 << (DAC_W-1));
    return r;
  endfunction

  function automatic int pre_val(input int i);
    return ((i * 1237 + 3) % 65536) - 32768;
  endfunction

  function automatic int sym_val(input int kind, input int s, input int i);
    if (kind == 0) begin
      return ((s * 7919 + i * 613 + 100) % 65536) - 32768;
    end
    case (i % 16)
      0:  return 32767;
      1:  return -32768;
      2:  return 32760;
      3:  return 32759;
      4:  return -32760;
      5:  return -32761;
      6:  return 7;
      7:  return 8;
      8:  return -8;
      9:  return -9;
      10: return 0;
      11: return 1000;
      12: return -1000;
      13: return 24;
      14: return -24;
      default: return 32751;
    endcase
  endfunction

  task automatic send_beat(input logic [P*IN_W-1:0] d, input bit last);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    s_last  = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // driver: loads the preamble, queues the expected beats, sends the symbols
  task automatic run_frame(input int nsym, input int pre, input int cp, input bit ob,
                           input int kind, input int bp, input bit stall_chk,
                           input string tag);
    int smp[$];
    @(negedge clk);
    cfg_cp_len     = 5'(cp);
    cfg_pre_len    = 7'(pre);
    cfg_offset_bin = ob;
    for (int i = 0; i < pre; i++) begin
      @(negedge clk);
      pre_we    = 1'b1;
      pre_addr  = 6'(i);
      pre_wdata = IN_W'(pre_val(i));
    end
    @(negedge clk);
    pre_we = 1'b0;
    for (int i = 0; i < pre; i++) smp.push_back(qref(pre_val(i), ob));
    for (int s = 0; s < nsym; s++) begin
      for (int i = SYM_N - cp; i < SYM_N; i++) smp.push_back(qref(sym_val(kind, s, i), ob));
      for (int i = 0; i < SYM_N; i++) smp.push_back(qref(sym_val(kind, s, i), ob));
    end
    for (int b = 0; b * P < smp.size(); b++) begin
      exp_t e;
      for (int l = 0; l < P; l++) begin
        int idx;
        idx = b * P + l;
        e.d[l*DAC_W +: DAC_W] = DAC_W'((idx < smp.size()) ? smp[idx] : qref(0, ob));
      end
      e.l   = ((b + 1) * P >= smp.size());
      e.tag = tag;
      sb.push_back(e);
    end
    bp_mode = stall_chk ? 2 : bp;
    for (int s = 0; s < nsym; s++) begin
      for (int b = 0; b < BEATS; b++) begin
        logic [P*IN_W-1:0] v;
        for (int l = 0; l < P; l++) v[l*IN_W +: IN_W] = IN_W'(sym_val(kind, s, b * P + l));
        send_beat(v, s == nsym - 1);
      end
      if (stall_chk && s == 1) begin
        @(negedge clk);
        s_valid = 1'b0;
        repeat (30) @(negedge clk);
        // R2: both banks hold a symbol while the output is stalled
        chk(s_ready == 1'b0, "R2 s_ready with both banks held", VW'(s_ready), VW'(0));
        bp_mode = bp;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    wait (sb.size() == 0);
    repeat (12) @(negedge clk);
    // R6: nothing follows the final beat of the frame
    chk(m_valid == 1'b0, "R6 idle after frame", VW'(m_valid), VW'(0));
  endtask

  // monitor: pops expected beats as the design delivers them
  initial begin
    int cyc;
    bit hold_pend;
    logic [VW-1:0] hold_d;
    logic hold_l;
    cyc = 0;
    hold_pend = 1'b0;
    hold_d = '0;
    hold_l = 1'b0;
    m_ready = 1'b0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      cyc++;
      case (bp_mode)
        0: m_ready = 1'b1;
        1: m_ready = (cyc % 3) != 0;
        default: m_ready = 1'b0;
      endcase
      if (hold_pend) begin
        // R10: a stalled beat keeps its contents
        chk(m_valid && (m_data == hold_d) && (m_last == hold_l), "R10 hold under stall",
            m_data, hold_d);
      end
      hold_pend = m_valid && !m_ready;
      hold_d    = m_data;
      hold_l    = m_last;
      if (m_valid && m_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R5 unexpected beat", m_data, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(m_data == e.d, e.tag, m_data, e.d);
          chk(m_last == e.l, {e.tag, " R6 last flag"}, VW'(m_last), VW'(e.l));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired with %0d beats outstanding", sb.size());
    finish_sim();
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    bp_mode = 0;
    mon_on = 1'b0;
    done = 1'b0;
    rst_n = 1'b0;
    cfg_cp_len = '0;
    cfg_pre_len = '0;
    cfg_offset_bin = 1'b0;
    pre_we = 1'b0;
    pre_addr = '0;
    pre_wdata = '0;
    s_valid = 1'b0;
    s_data = '0;
    s_last = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(m_valid == 1'b0, "R1 m_valid after reset", VW'(m_valid), VW'(0));
    chk(m_last == 1'b0, "R1 m_last after reset", VW'(m_last), VW'(0));
    chk(s_ready == 1'b1, "R1 s_ready after reset", VW'(s_ready), VW'(1));
    mon_on = 1'b1;
    // R3 R4 R5: preamble of 16, prefix of 8, two symbols, aligned lengths
    run_frame(2, 16, 8, 1'b0, 0, 0, 1'b0, "R3/R4/R5 aligned frame");
    // R2 R5 R9: odd preamble and prefix, offset binary, output back-pressure
    run_frame(3, 5, 13, 1'b1, 0, 1, 1'b1, "R2/R5/R9 unaligned frame");
    // R7 R8: rounding and saturation extremes, no preamble, longest prefix
    run_frame(1, 0, 16, 1'b0, 1, 0, 1'b0, "R7/R8 extremes two's complement");
    // R8 R9: same extremes in offset binary
    run_frame(1, 0, 16, 1'b1, 1, 1, 1'b0, "R8/R9 extremes offset binary");
    // R4 R6: no prefix, short preamble, partial final beat with padding
    run_frame(2, 3, 0, 1'b0, 0, 0, 1'b0, "R4/R6 no prefix padded end");
    finish_sim();
  end

endmodule